// File: doc/BRIEF.md
# Paged Slot Select Decoder

This block turns the memory and I/O strobes of an 8-bit CPU bus into chip selects for a machine whose 64K address space is assembled from four slots. The top two address bits pick one of four 16K pages. A byte-wide primary register gives each page its own primary slot. Software writes this register at an I/O port and can also read it back. Slots 1 and 2 lead to cartridge connectors, so for them the block only asserts a select. Slot 0 holds the 48K system ROM.

Slot 3 is expanded into four subslots. A secondary register, mapped at the top byte of memory, picks a subslot for each page. Only the top byte of that register is decoded, and only while page 3 is routed to slot 3. Reading that byte returns the inverted register contents. Subslot 0 carries a 16K sub-BIOS ROM, subslot 1 is empty, subslot 2 carries mapped RAM, and subslot 3 carries a banked ROM-mapper window. Bank registers are outside this block; it only says which device owns the current cycle.

Top module: `slot_decoder`

## Requirements
- R1: After reset both registers read as zero, so a memory read at $0000 asserts only the system ROM select.
- R2: An I/O write (iorq_i and wr_i high, mreq_i low) whose low address byte is $A8 loads data_i into the primary register on that clock edge. An I/O read of port $A8 drives the register value on data_o with data_oe_o high.
- R3: For a memory cycle, the page is addr_i[15:14], and the primary slot for page n is primary register bits [2n+1:2n].
- R4: In primary slot 0, pages 0, 1 and 2 assert bios_cs_o and page 3 asserts no select.
- R5: Primary slot 1 asserts cart1_cs_o and primary slot 2 asserts cart2_cs_o, on any page.
- R6: In primary slot 3, the subslot for page n is secondary register bits [2n+1:2n]. Subslot 0 asserts subrom_cs_o on page 0 only. Subslot 1 asserts nothing. Subslot 2 asserts ram_cs_o on every page. Subslot 3 asserts rommap_cs_o on pages 1 and 2 only.
- R7: When primary bits [7:6] equal 3, a memory write to $FFFF loads the secondary register and asserts no select. A memory read of $FFFF then drives the inverted register on data_o with data_oe_o high and asserts no select.
- R8: When primary bits [7:6] are not 3, an access to $FFFF is an ordinary page-3 access and the secondary register keeps its value.
- R9: A select is asserted only while mreq_i is high, and at most one select is high at a time. When data_oe_o is low, data_o is zero.
- R10: I/O writes to any port other than $A8, and memory writes, leave the primary register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 16 | CPU address |
| data_i | input | 8 | CPU write data |
| mreq_i | input | 1 | Memory request, active high |
| iorq_i | input | 1 | I/O request, active high |
| rd_i | input | 1 | Read strobe, active high |
| wr_i | input | 1 | Write strobe, active high |
| data_o | output | 8 | Register readback data |
| data_oe_o | output | 1 | Readback drive enable |
| bios_cs_o | output | 1 | System BIOS/BASIC ROM select |
| subrom_cs_o | output | 1 | Sub-BIOS ROM select |
| rommap_cs_o | output | 1 | ROM-mapper window select |
| ram_cs_o | output | 1 | Mapped RAM select |
| cart1_cs_o | output | 1 | Cartridge slot 1 select |
| cart2_cs_o | output | 1 | Cartridge slot 2 select |

## Verification
The hardest case to reach is a write to $FFFF that looks like a secondary-register write but must not be one, because page 3 is routed elsewhere at that moment. To get there, the stimulus first loads the secondary register with slot 3 on top. It then reroutes page 3 to slot 0, writes a new value at $FFFF, and restores slot 3. Reading the inverted register back then shows whether the value survived. The subslot checks also use two secondary values that place every subslot on a page where it is live and on a page where it is masked.

// File: rtl/slot_dec_pkg.sv
package slot_dec_pkg;
  localparam int PAGES    = 4;
  localparam int SLOT_W   = 2;
  localparam int REG_W    = PAGES * SLOT_W;
  localparam int PAGE_W   = $clog2(PAGES);
  localparam logic [7:0]  PRIM_PORT = 8'hA8;
  localparam logic [15:0] SEC_ADDR  = 16'hFFFF;
  localparam logic [SLOT_W-1:0] EXP_SLOT = 2'd3;

  typedef enum logic [SLOT_W-1:0] {
    PRI_SYS  = 2'd0,
    PRI_CRT1 = 2'd1,
    PRI_CRT2 = 2'd2,
    PRI_EXP  = 2'd3
  } prim_e;

  typedef enum logic [SLOT_W-1:0] {
    SUB_BOOT   = 2'd0,
    SUB_EMPTY  = 2'd1,
    SUB_RAM    = 2'd2,
    SUB_MAPPER = 2'd3
  } sub_e;

  typedef struct packed {
    logic bios;
    logic subrom;
    logic rommap;
    logic ram;
    logic cart1;
    logic cart2;
  } cs_t;
endpackage

// File: rtl/slot_sel_reg.sv
module slot_sel_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/slot_field_split.sv
module slot_field_split #(
  parameter int PAGES  = 4,
  parameter int SLOT_W = 2,
  localparam int REG_W = PAGES * SLOT_W
) (
  input  logic [REG_W-1:0]             reg_i,
  output logic [PAGES-1:0][SLOT_W-1:0] field_o
);
  for (genvar p = 0; p < PAGES; p++) begin : g_page
    assign field_o[p] = reg_i[p*SLOT_W +: SLOT_W];
  end
endmodule

// File: rtl/slot_cs_decode.sv
module slot_cs_decode
  import slot_dec_pkg::*;
#(
  parameter int BIOS_PAGES   = 3,
  parameter int SUBROM_PAGE  = 0,
  parameter int MAPPER_FIRST = 1,
  parameter int MAPPER_LAST  = 2
) (
  input  logic              mreq_i,
  input  logic              sec_hit_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [SLOT_W-1:0] prim_i,
  input  logic [SLOT_W-1:0] sub_i,
  output cs_t               cs_o
);
  localparam logic [PAGE_W-1:0] SUBROM_PG = PAGE_W'(SUBROM_PAGE);
  localparam logic [PAGE_W-1:0] MAP_LO    = PAGE_W'(MAPPER_FIRST);
  localparam logic [PAGE_W-1:0] MAP_HI    = PAGE_W'(MAPPER_LAST);
  localparam int               BIOS_TOP  = BIOS_PAGES;

  always_comb begin
    cs_o = '0;
    if (mreq_i && !sec_hit_i) begin
      unique case (prim_e'(prim_i))
        PRI_SYS:  cs_o.bios  = (int'(page_i) < BIOS_TOP);
        PRI_CRT1: cs_o.cart1 = 1'b1;
        PRI_CRT2: cs_o.cart2 = 1'b1;
        PRI_EXP: begin
          unique case (sub_e'(sub_i))
            SUB_BOOT:   cs_o.subrom = (page_i == SUBROM_PG);
            SUB_EMPTY:  ;
            SUB_RAM:    cs_o.ram    = 1'b1;
            SUB_MAPPER: cs_o.rommap = (page_i >= MAP_LO) && (page_i <= MAP_HI);
            default:    ;
          endcase
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/slot_decoder.sv
module slot_decoder
  import slot_dec_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int IO_ADDR_W = 8,
  localparam int DATA_W   = REG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              mreq_i,
  input  logic              iorq_i,
  input  logic              rd_i,
  input  logic              wr_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              bios_cs_o,
  output logic              subrom_cs_o,
  output logic              rommap_cs_o,
  output logic              ram_cs_o,
  output logic              cart1_cs_o,
  output logic              cart2_cs_o
);
  logic [REG_W-1:0] prim_q, sec_q;
  logic [PAGES-1:0][SLOT_W-1:0] prim_f, sec_f;
  logic [PAGE_W-1:0] page;
  logic io_hit, io_wr, io_rd, sec_hit, sec_wr, sec_rd;
  cs_t  cs;

  assign page    = addr_i[ADDR_W-1 -: PAGE_W];
  assign io_hit  = iorq_i && !mreq_i && (addr_i[IO_ADDR_W-1:0] == IO_ADDR_W'(PRIM_PORT));
  assign io_wr   = io_hit && wr_i;
  assign io_rd   = io_hit && rd_i;
  // secondary register only visible while page 3 sits in the expanded slot
  assign sec_hit = mreq_i && (addr_i == ADDR_W'(SEC_ADDR)) && (prim_f[PAGES-1] == EXP_SLOT);
  assign sec_wr  = sec_hit && wr_i;
  assign sec_rd  = sec_hit && rd_i;

  slot_sel_reg #(.W(REG_W)) u_prim_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(io_wr), .d_i(data_i), .q_o(prim_q)
  );

  slot_sel_reg #(.W(REG_W)) u_sec_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(sec_wr), .d_i(data_i), .q_o(sec_q)
  );

  slot_field_split #(.PAGES(PAGES), .SLOT_W(SLOT_W)) u_prim_split (
    .reg_i(prim_q), .field_o(prim_f)
  );

  slot_field_split #(.PAGES(PAGES), .SLOT_W(SLOT_W)) u_sec_split (
    .reg_i(sec_q), .field_o(sec_f)
  );

  slot_cs_decode u_cs_decode (
    .mreq_i(mreq_i), .sec_hit_i(sec_hit), .page_i(page),
    .prim_i(prim_f[page]), .sub_i(sec_f[page]), .cs_o(cs)
  );

  always_comb begin
    data_o    = '0;
    data_oe_o = 1'b0;
    if (io_rd) begin
      data_o    = prim_q;
      data_oe_o = 1'b1;
    end else if (sec_rd) begin
      data_o    = ~sec_q;
      data_oe_o = 1'b1;
    end
  end

  assign bios_cs_o   = cs.bios;
  assign subrom_cs_o = cs.subrom;
  assign rommap_cs_o = cs.rommap;
  assign ram_cs_o    = cs.ram;
  assign cart1_cs_o  = cs.cart1;
  assign cart2_cs_o  = cs.cart2;
endmodule

// File: rtl/slot_decoder_chk.sv
module slot_decoder_chk
  import slot_dec_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic [15:0] addr_i,
  input logic [7:0]  data_i,
  input logic        mreq_i,
  input logic        iorq_i,
  input logic        rd_i,
  input logic        wr_i,
  input logic [7:0]  prim_q,
  input logic [7:0]  sec_q,
  input logic [7:0]  data_o,
  input logic        data_oe_o,
  input logic [5:0]  cs_vec
);
  logic prim_we, sec_acc;
  assign prim_we = iorq_i && wr_i && !mreq_i && (addr_i[7:0] == PRIM_PORT);
  assign sec_acc = mreq_i && (addr_i == SEC_ADDR) && (prim_q[7:6] == EXP_SLOT);

  AST_CS_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cs_vec)); // R9
  AST_CS_NEEDS_MREQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mreq_i |-> (cs_vec == '0)); // R9
  AST_IDLE_DATA_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_oe_o |-> (data_o == '0)); // R9
  AST_PRIM_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prim_we |=> (prim_q == $past(data_i))); // R2
  AST_PRIM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prim_we |=> $stable(prim_q)); // R10
  AST_SEC_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_acc && wr_i) |=> (sec_q == $past(data_i))); // R7
  AST_SEC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sec_acc && wr_i) |=> $stable(sec_q)); // R8
  AST_SEC_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_acc && rd_i) |-> (data_oe_o && (data_o == ~sec_q) && (cs_vec == '0))); // R7
  AST_PAGE3_SYS_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mreq_i && addr_i[15:14] == 2'd3 && prim_q[7:6] == 2'd0) |-> !cs_vec[5]); // R4
endmodule

bind slot_decoder slot_decoder_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .data_i(data_i),
  .mreq_i(mreq_i), .iorq_i(iorq_i), .rd_i(rd_i), .wr_i(wr_i),
  .prim_q(prim_q), .sec_q(sec_q), .data_o(data_o), .data_oe_o(data_oe_o),
  .cs_vec({bios_cs_o, subrom_cs_o, rommap_cs_o, ram_cs_o, cart1_cs_o, cart2_cs_o})
);

// File: tb/slot_decoder_bench.sv
`timescale 1ns/1ps
module slot_decoder_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic mreq = 1'b0, iorq = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [7:0] rdata;
  logic oe, bios, subrom, rommap, ram, cart1, cart2;

  always #2 clk = ~clk; // 250 MHz

  slot_decoder u_slot_decoder (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .data_i(wdata),
    .mreq_i(mreq), .iorq_i(iorq), .rd_i(rd), .wr_i(wr),
    .data_o(rdata), .data_oe_o(oe),
    .bios_cs_o(bios), .subrom_cs_o(subrom), .rommap_cs_o(rommap),
    .ram_cs_o(ram), .cart1_cs_o(cart1), .cart2_cs_o(cart2)
  );

  typedef struct {
    string      tag;
    logic [5:0] cs;   // {bios,subrom,rommap,ram,cart1,cart2}
    logic       oe;
    logic [7:0] d;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;
  logic [7:0] m_prim = '0, m_sec = '0;

  function automatic exp_t model(string tag, logic [15:0] a, logic mq, logic io,
                                 logic r, logic w);
    exp_t e;
    logic [1:0] pg, ps, ss;
    bit sec;
    e.tag = tag; e.cs = '0; e.oe = 1'b0; e.d = '0;
    pg  = a[15:14];
    ps  = m_prim[2*pg +: 2];
    ss  = m_sec[2*pg +: 2];
    sec = mq && a == 16'hFFFF && m_prim[7:6] == 2'd3;
    if (io && !mq && r && a[7:0] == 8'hA8) begin e.oe = 1'b1; e.d = m_prim; end
    if (sec && r) begin e.oe = 1'b1; e.d = ~m_sec; end
    if (mq && !sec) begin
      case (ps)
        2'd0: e.cs[5] = (pg != 2'd3);
        2'd1: e.cs[1] = 1'b1;
        2'd2: e.cs[0] = 1'b1;
        default: case (ss)
          2'd0: e.cs[4] = (pg == 2'd0);
          2'd2: e.cs[2] = 1'b1;
          2'd3: e.cs[3] = (pg == 2'd1 || pg == 2'd2);
          default: ;
        endcase
      endcase
    end
    return e;
  endfunction

  task automatic access(string tag, logic [15:0] a, logic mq, logic io,
                        logic r, logic w, logic [7:0] d);
    @(negedge clk);
    addr = a; mreq = mq; iorq = io; rd = r; wr = w; wdata = d;
    exp_q.push_back(model(tag, a, mq, io, r, w));
    if (io && !mq && w && a[7:0] == 8'hA8) m_prim = d;
    if (mq && w && a == 16'hFFFF && m_prim[7:6] == 2'd3) m_sec = d;
  endtask

  task automatic mrd(string tag, logic [15:0] a); access(tag, a, 1, 0, 1, 0, 8'h00); endtask
  task automatic mwr(string tag, logic [15:0] a, logic [7:0] d); access(tag, a, 1, 0, 0, 1, d); endtask
  task automatic iord(string tag, logic [15:0] a); access(tag, a, 0, 1, 1, 0, 8'h00); endtask
  task automatic iowr(string tag, logic [15:0] a, logic [7:0] d); access(tag, a, 0, 1, 0, 1, d); endtask

  // monitor: compare 1 ns after the driving edge, well before the next rising edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        logic [5:0] got;
        e = exp_q.pop_front();
        got = {bios, subrom, rommap, ram, cart1, cart2};
        n_chk++;
        if (got !== e.cs || oe !== e.oe || rdata !== e.d) begin
          n_fail++;
          $display("FAIL %s: cs=%b oe=%b d=%h expected cs=%b oe=%b d=%h",
                   e.tag, got, oe, rdata, e.cs, e.oe, e.d);
        end
      end
    end
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    mrd("R1", 16'h0000);
    iord("R1", 16'h00A8);
    // R4 slot 0 pages
    mrd("R4", 16'h4000);
    mrd("R4", 16'h8000);
    mrd("R4", 16'hC000);
    // R2 R3 R5 per-page primary routing: p0=0 p1=1 p2=2 p3=0
    iowr("R2", 16'h12A8, 8'h24);
    iord("R2", 16'h00A8);
    mrd("R3", 16'h0123);
    mrd("R5", 16'h4000);
    mrd("R5", 16'hBFFF);
    mrd("R3", 16'hC000);
    // p0=2 p1=1 p2=0 p3=1
    iowr("R3", 16'h00A8, 8'h46);
    mrd("R5", 16'h0000);
    mwr("R5", 16'h7FFF, 8'h55);
    mrd("R4", 16'h8000);
    mrd("R5", 16'hFFFF);
    // R10 other port / memory writes leave primary alone
    iowr("R10", 16'h00A9, 8'hFF);
    mwr("R10", 16'h00A8, 8'hFF);
    iord("R10", 16'h00A8);
    // R7 secondary register
    iowr("R7", 16'h00A8, 8'hFF);
    mrd("R7", 16'hFFFF);
    mwr("R7", 16'hFFFF, 8'h9C);     // p0=0 p1=3 p2=1 p3=2
    mrd("R7", 16'hFFFF);
    mrd("R6", 16'h0000);
    mrd("R6", 16'h4000);
    mrd("R6", 16'h8000);
    mrd("R6", 16'hC000);
    mwr("R7", 16'hFFFF, 8'hF2);     // p0=2 p1=0 p2=3 p3=3
    mrd("R6", 16'h0000);
    mrd("R6", 16'h4000);
    mrd("R6", 16'h8000);
    mrd("R6", 16'hC000);
    mrd("R6", 16'hFFFE);
    // R8 $FFFF outside the expanded slot
    iowr("R8", 16'h00A8, 8'h3F);
    mwr("R8", 16'hFFFF, 8'h00);
    iowr("R8", 16'h00A8, 8'h7F);
    mrd("R8", 16'hFFFF);
    iowr("R8", 16'h00A8, 8'hFF);
    mrd("R8", 16'hFFFF);
    // R9 no selects without mreq, idle data zero
    access("R9", 16'h0000, 0, 1, 1, 0, 8'h00);
    access("R9", 16'hC000, 0, 0, 1, 0, 8'h00);
    iord("R9", 16'h00A7);
    access("R9", 16'h00A8, 0, 0, 0, 0, 8'h00);
    @(negedge clk);
    mreq = 0; iorq = 0; rd = 0; wr = 0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule